// File: doc/BRIEF.md
# USB PHY Clock and Reset Bring-Up Sequencer

This block brings a USB host controller and its PHY from power-up to operation with no software involved. Several clients share the controller. Each client raises a one-cycle start request when it needs the controller and a one-cycle stop request when it is finished. The block keeps a count of active clients. Only a start that arrives while the count is zero launches the bring-up walk.

The walk runs in a fixed order. It first enables the interface. It then holds the PHY in power-on reset while it sets up the reference clock selection, the reference divider code and the host clock divider. Next it starts the host clock divider and lets it settle. After that it releases power-on reset and waits for the PHY clock. It then pulses the PHY test reset, starts the full-speed clock divider, and finally releases the PHY and the host controller from reset.

Every wait is counted in I/O clock cycles. Each wait length is derived from the I/O clock frequency parameter and rounded up. When the walk begins, the block checks whether the host controller is already out of reset. If it is, the block goes straight to done and touches nothing else.

Top module: `usbphy_bringup_seq`

## Requirements
- R1: Each start request with no stop raises `clients` by one, and it saturates at its maximum. Each stop with no start lowers `clients` by one, and it never goes below zero. A start and a stop in the same cycle leave `clients` unchanged. Only a start that arrives while `clients` is 0 and the block is not busy launches the walk.
- R2: The first step of the walk sets `if_en`. If `host_reset_n` is already 1 at that point, the block goes to done after exactly two busy cycles and never raises `phy_por`.
- R3: When `phy_por` rises, `if_en` is 1 and all of these are 0: `hdiv_en`, `hdiv_rst_n`, `fs_en`, `fs_rst_n`, `phy_reset_n` and `host_reset_n`.
- R4: `ref_div` is 0 when `ref_mhz` is 12, 1 when it is 24 and 2 when it is 48. Any other value of `ref_mhz` gives 0 and sets `rate_err` to 1. A legal value leaves `rate_err` at 0.
- R5: `ref_sel` is 0 when `ref_crystal` is 1 (crystal), and 1 when `ref_crystal` is 0 (external clock).
- R6: `host_div` is chosen from N = `io_ratio` (the I/O clock rate divided by 130 MHz), as follows:

  | N | host_div |
  |---|---|
  | 0 | 1 |
  | 1 to 4 | N |
  | 5 | 4 |
  | 6 or 7 | 6 |
  | 8 to 11 | 8 |
  | 12 or more | 12 |

- R7: `hdiv_en` rises before `hdiv_rst_n` rises (1 means the divider is out of reset). After `hdiv_rst_n` rises, `phy_por` falls no sooner than 64 cycles later and no later than 67 cycles later.
- R8: After `phy_por` falls, `ate_rst` rises no sooner than one millisecond of I/O cycles later, and at most 3 cycles after that. The `ate_rst` pulse lasts at least the number of cycles in 10 ns. After the pulse ends, `fs_rst_n` rises no sooner than the number of cycles in 20 ns.
- R9: `fs_rst_n` rises before `fs_en` rises. After `fs_en` rises, `phy_reset_n` rises 64 to 67 cycles later. After that, `host_reset_n` rises no sooner than one microsecond of cycles later and at most 3 cycles after that. For both reset outputs, 1 means out of reset.
- R10: `done` is 1 exactly while the walk has finished, and `host_reset_n` is then 1. `busy` is 1 while the walk runs. `busy` and `done` are never both 1. A start that arrives while `busy` is 1 only raises `clients` and does not restart the walk.
- R11: While `rst` is 1, and in the cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle client start request |
| stop_req | input | 1 | One-cycle client stop request |
| ref_mhz | input | 7 | Reference clock rate in MHz |
| ref_crystal | input | 1 | 1 when the reference is a crystal |
| io_ratio | input | RATIO_W | I/O clock rate divided by 130 MHz |
| if_en | output | 1 | Interface enable |
| ref_sel | output | 1 | Reference source select (0 means crystal) |
| ref_div | output | 2 | Reference divider code |
| rate_err | output | 1 | An unsupported reference rate was given |
| host_div | output | 4 | Host clock divider value |
| hdiv_en | output | 1 | Host clock divider enable |
| hdiv_rst_n | output | 1 | Host clock divider reset, active low |
| phy_por | output | 1 | PHY power-on reset |
| ate_rst | output | 1 | PHY test reset pulse |
| fs_rst_n | output | 1 | Full-speed divider reset, active low |
| fs_en | output | 1 | Full-speed divider enable |
| phy_reset_n | output | 1 | PHY reset, active low |
| host_reset_n | output | 1 | Host controller reset, active low |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished |
| clients | output | CLIENT_W | Number of active clients |

## Verification
The hardest case to reach is the skip path. It needs the host controller to be already out of reset when a fresh first start arrives, and no reset may come in between. The bench completes one walk, raises the client count to three, and drains it back to zero. It then issues a new start and checks three things: `busy` lasts exactly two cycles, `phy_por` never rises, and `done` returns. A second hard case is a start that arrives in the middle of a walk. The bench injects one during the long wait after `phy_por` falls, and it checks that the walk raises `phy_por` only once.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    localparam int unsigned RATIO_W = 5;

    typedef enum logic [4:0] {
        ST_IDLE, ST_IFEN, ST_CHECK, ST_POR, ST_REF, ST_HDIV, ST_HEN,
        ST_HREL, ST_PORREL, ST_ATE_ON, ST_ATE_OFF, ST_FSREL, ST_FSEN,
        ST_PHYREL, ST_HOSTREL, ST_WAIT, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic if_en;
        logic phy_por;
        logic hdiv_en;
        logic hdiv_rst_n;
        logic ate_rst;
        logic fs_rst_n;
        logic fs_en;
        logic phy_reset_n;
        logic host_reset_n;
    } ctl_pins_t;

    typedef struct packed {
        logic [1:0] code;
        logic       err;
    } refclk_cfg_t;

    // Round-up conversion of a frequency to cycles per interval (1/per_sec s).
    function automatic longint unsigned cycles_ceil(input longint unsigned hz,
                                                    input longint unsigned per_sec);
        return (hz + per_sec - 1) / per_sec;
    endfunction

    // Non-linear host divider choice from the I/O-to-130MHz ratio.
    function automatic logic [3:0] pick_host_div(input int unsigned n);
        if (n == 0)       return 4'd1;
        else if (n <= 4)  return 4'(n);
        else if (n == 5)  return 4'd4;
        else if (n <= 7)  return 4'd6;
        else if (n <= 11) return 4'd8;
        else              return 4'd12;
    endfunction

    function automatic refclk_cfg_t decode_refclk(input logic [6:0] mhz);
        refclk_cfg_t c;
        case (mhz)
            7'd12:   c = '{code: 2'd0, err: 1'b0};
            7'd24:   c = '{code: 2'd1, err: 1'b0};
            7'd48:   c = '{code: 2'd2, err: 1'b0};
            default: c = '{code: 2'd0, err: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/usbphy_client_count.sv
module usbphy_client_count #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         stop_req,
    output logic [W-1:0] count,
    output logic         launch
);
    localparam logic [W-1:0] CNT_MAX = '1;

    assign launch = start_req && !stop_req && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (start_req && !stop_req && count != CNT_MAX) begin
            count <= count + 1'b1;
        end else if (stop_req && !start_req && count != '0) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/usbphy_wait_timer.sv
module usbphy_wait_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/usbphy_bringup_seq.sv
module usbphy_bringup_seq
    import usbphy_seq_pkg::*;
#(
    parameter int unsigned IO_CLK_HZ  = 250_000_000,
    parameter int unsigned CLIENT_W   = 4,
    parameter int unsigned RATIO_W    = usbphy_seq_pkg::RATIO_W,
    parameter int unsigned DIV_SETTLE = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    input  logic                stop_req,
    input  logic [6:0]          ref_mhz,
    input  logic                ref_crystal,
    input  logic [RATIO_W-1:0]  io_ratio,
    output logic                if_en,
    output logic                ref_sel,
    output logic [1:0]          ref_div,
    output logic                rate_err,
    output logic [3:0]          host_div,
    output logic                hdiv_en,
    output logic                hdiv_rst_n,
    output logic                phy_por,
    output logic                ate_rst,
    output logic                fs_rst_n,
    output logic                fs_en,
    output logic                phy_reset_n,
    output logic                host_reset_n,
    output logic                busy,
    output logic                done,
    output logic [CLIENT_W-1:0] clients
);
    localparam longint unsigned MS_CYC   = cycles_ceil(64'(IO_CLK_HZ), 64'd1_000);
    localparam longint unsigned US_CYC   = cycles_ceil(64'(IO_CLK_HZ), 64'd1_000_000);
    localparam longint unsigned NS10_CYC = cycles_ceil(64'(IO_CLK_HZ), 64'd100_000_000);
    localparam longint unsigned NS20_CYC = cycles_ceil(64'(IO_CLK_HZ), 64'd50_000_000);
    localparam longint unsigned MAX_CYC  = (MS_CYC > 64'(DIV_SETTLE)) ? MS_CYC : 64'(DIV_SETTLE);
    localparam int unsigned     TW       = $clog2(MAX_CYC + 1);

    seq_state_e  state, ret_state;
    ctl_pins_t   pins;
    refclk_cfg_t ref_cfg;
    logic        launch, tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    usbphy_client_count #(.W(CLIENT_W)) u_count (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .count(clients), .launch(launch)
    );

    usbphy_wait_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    assign ref_cfg = decode_refclk(ref_mhz);

    // Wait lengths, loaded as the action state hands over to ST_WAIT.
    always_comb begin
        tmr_load = 1'b1;
        case (state)
            ST_HREL:    tmr_val = TW'(DIV_SETTLE - 1);
            ST_PORREL:  tmr_val = TW'(MS_CYC - 1);
            ST_ATE_ON:  tmr_val = TW'(NS10_CYC - 1);
            ST_ATE_OFF: tmr_val = TW'(NS20_CYC - 1);
            ST_FSEN:    tmr_val = TW'(DIV_SETTLE - 1);
            ST_PHYREL:  tmr_val = TW'(US_CYC - 1);
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ret_state <= ST_IDLE;
            pins      <= '0;
            ref_sel   <= 1'b0;
            ref_div   <= 2'd0;
            rate_err  <= 1'b0;
            host_div  <= 4'd0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: if (launch) state <= ST_IFEN;
                ST_IFEN: begin
                    pins.if_en <= 1'b1;
                    state      <= ST_CHECK;
                end
                ST_CHECK: state <= pins.host_reset_n ? ST_DONE : ST_POR;
                ST_POR: begin
                    pins.phy_por      <= 1'b1;
                    pins.hdiv_en      <= 1'b0;
                    pins.hdiv_rst_n   <= 1'b0;
                    pins.fs_en        <= 1'b0;
                    pins.fs_rst_n     <= 1'b0;
                    pins.phy_reset_n  <= 1'b0;
                    pins.host_reset_n <= 1'b0;
                    state             <= ST_REF;
                end
                ST_REF: begin
                    ref_sel  <= !ref_crystal;
                    ref_div  <= ref_cfg.code;
                    rate_err <= ref_cfg.err;
                    state    <= ST_HDIV;
                end
                ST_HDIV: begin
                    host_div <= pick_host_div(int'(io_ratio));
                    state    <= ST_HEN;
                end
                ST_HEN: begin
                    pins.hdiv_en <= 1'b1;
                    state        <= ST_HREL;
                end
                ST_HREL: begin
                    pins.hdiv_rst_n <= 1'b1;
                    ret_state       <= ST_PORREL;
                    state           <= ST_WAIT;
                end
                ST_PORREL: begin
                    pins.phy_por <= 1'b0;
                    ret_state    <= ST_ATE_ON;
                    state        <= ST_WAIT;
                end
                ST_ATE_ON: begin
                    pins.ate_rst <= 1'b1;
                    ret_state    <= ST_ATE_OFF;
                    state        <= ST_WAIT;
                end
                ST_ATE_OFF: begin
                    pins.ate_rst <= 1'b0;
                    ret_state    <= ST_FSREL;
                    state        <= ST_WAIT;
                end
                ST_FSREL: begin
                    pins.fs_rst_n <= 1'b1;
                    state         <= ST_FSEN;
                end
                ST_FSEN: begin
                    pins.fs_en <= 1'b1;
                    ret_state  <= ST_PHYREL;
                    state      <= ST_WAIT;
                end
                ST_PHYREL: begin
                    pins.phy_reset_n <= 1'b1;
                    ret_state        <= ST_HOSTREL;
                    state            <= ST_WAIT;
                end
                ST_HOSTREL: begin
                    pins.host_reset_n <= 1'b1;
                    state             <= ST_DONE;
                end
                ST_WAIT: if (tmr_zero) state <= ret_state;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign if_en        = pins.if_en;
    assign phy_por      = pins.phy_por;
    assign hdiv_en      = pins.hdiv_en;
    assign hdiv_rst_n   = pins.hdiv_rst_n;
    assign ate_rst      = pins.ate_rst;
    assign fs_rst_n     = pins.fs_rst_n;
    assign fs_en        = pins.fs_en;
    assign phy_reset_n  = pins.phy_reset_n;
    assign host_reset_n = pins.host_reset_n;
    assign done         = (state == ST_DONE);
    assign busy         = (state != ST_IDLE) && (state != ST_DONE);
endmodule

// File: rtl/usbphy_seq_checks.sv
module usbphy_seq_checks #(
    parameter int unsigned CLIENT_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                start_req,
    input logic                stop_req,
    input logic                if_en,
    input logic [1:0]          ref_div,
    input logic                hdiv_en,
    input logic                hdiv_rst_n,
    input logic                phy_por,
    input logic                ate_rst,
    input logic                fs_rst_n,
    input logic                fs_en,
    input logic                phy_reset_n,
    input logic                host_reset_n,
    input logic                busy,
    input logic                done,
    input logic [CLIENT_W-1:0] clients
);
    localparam logic [CLIENT_W-1:0] CMAX = '1;

    p_count_up_r1: assert property (@(posedge clk) disable iff (rst)
        (start_req && !stop_req && clients != CMAX) |=> clients == CLIENT_W'($past(clients) + 1'b1));

    p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (start_req && stop_req) |=> $stable(clients));

    p_por_only_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_por) |-> !host_reset_n);

    p_por_step_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_por) |-> (if_en && !hdiv_en && !hdiv_rst_n && !fs_en && !fs_rst_n && !phy_reset_n));

    p_refdiv_legal_r4: assert property (@(posedge clk) disable iff (rst)
        ref_div != 2'd3);

    p_hdiv_order_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(hdiv_rst_n) |-> hdiv_en);

    p_ate_window_r8: assert property (@(posedge clk) disable iff (rst)
        ate_rst |-> (!phy_por && hdiv_rst_n && !fs_rst_n));

    p_fs_order_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_en) |-> fs_rst_n);

    p_host_last_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(host_reset_n) |-> (phy_reset_n && fs_en && !ate_rst && !phy_por));

    p_busy_done_r10: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_done_host_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> host_reset_n);
endmodule

bind usbphy_bringup_seq usbphy_seq_checks #(.CLIENT_W(CLIENT_W)) u_checks (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .if_en(if_en), .ref_div(ref_div), .hdiv_en(hdiv_en), .hdiv_rst_n(hdiv_rst_n),
    .phy_por(phy_por), .ate_rst(ate_rst), .fs_rst_n(fs_rst_n), .fs_en(fs_en),
    .phy_reset_n(phy_reset_n), .host_reset_n(host_reset_n),
    .busy(busy), .done(done), .clients(clients)
);

// File: tb/usbphy_bringup_seq_test.sv
module usbphy_bringup_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int IO_HZ      = 10_000_000;
    localparam int MS_C       = 10_000;
    localparam int US_C       = 10;
    localparam int CW         = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, stop_req = 1'b0;
    logic [6:0] ref_mhz = 7'd12;
    logic ref_crystal = 1'b0;
    logic [4:0] io_ratio = 5'd0;
    logic if_en, ref_sel, rate_err, hdiv_en, hdiv_rst_n, phy_por, ate_rst;
    logic fs_rst_n, fs_en, phy_reset_n, host_reset_n, busy, done;
    logic [1:0] ref_div;
    logic [3:0] host_div;
    logic [CW-1:0] clients;

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbphy_bringup_seq #(.IO_CLK_HZ(IO_HZ), .CLIENT_W(CW)) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .ref_mhz(ref_mhz), .ref_crystal(ref_crystal), .io_ratio(io_ratio),
        .if_en(if_en), .ref_sel(ref_sel), .ref_div(ref_div), .rate_err(rate_err),
        .host_div(host_div), .hdiv_en(hdiv_en), .hdiv_rst_n(hdiv_rst_n),
        .phy_por(phy_por), .ate_rst(ate_rst), .fs_rst_n(fs_rst_n), .fs_en(fs_en),
        .phy_reset_n(phy_reset_n), .host_reset_n(host_reset_n),
        .busy(busy), .done(done), .clients(clients)
    );

    // Edge monitor: cycle stamps of output transitions, sampled at negedge.
    int cyc = 0, por_rises = 0, busy_cyc = 0;
    int t_hen = 0, t_hrel = 0, t_porfall = 0, t_ate_on = 0, t_ate_off = 0;
    int t_fsrel = 0, t_fsen = 0, t_phy = 0, t_host = 0;
    logic p_hen = 0, p_hrel = 0, p_por = 0, p_ate = 0, p_fsr = 0, p_fse = 0, p_phy = 0, p_host = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (busy) busy_cyc <= busy_cyc + 1;
        if (hdiv_en && !p_hen)       t_hen <= cyc;
        if (hdiv_rst_n && !p_hrel)   t_hrel <= cyc;
        if (phy_por && !p_por)       por_rises <= por_rises + 1;
        if (!phy_por && p_por)       t_porfall <= cyc;
        if (ate_rst && !p_ate)       t_ate_on <= cyc;
        if (!ate_rst && p_ate)       t_ate_off <= cyc;
        if (fs_rst_n && !p_fsr)      t_fsrel <= cyc;
        if (fs_en && !p_fse)         t_fsen <= cyc;
        if (phy_reset_n && !p_phy)   t_phy <= cyc;
        if (host_reset_n && !p_host) t_host <= cyc;
        p_hen <= hdiv_en; p_hrel <= hdiv_rst_n; p_por <= phy_por; p_ate <= ate_rst;
        p_fsr <= fs_rst_n; p_fse <= fs_en; p_phy <= phy_reset_n; p_host <= host_reset_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input bit s, input bit p);
        @(negedge clk); start_req = s; stop_req = p;
        @(negedge clk); start_req = 1'b0; stop_req = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [4:0] n;
        logic [6:0] mhz;
        logic       xtal;
        logic [3:0] hdiv;
        logic [1:0] rdiv;
        logic       rsel;
        logic       err;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{n: 5'd0,  mhz: 7'd12, xtal: 1'b1, hdiv: 4'd1,  rdiv: 2'd0, rsel: 1'b0, err: 1'b0},
        '{n: 5'd3,  mhz: 7'd24, xtal: 1'b0, hdiv: 4'd3,  rdiv: 2'd1, rsel: 1'b1, err: 1'b0},
        '{n: 5'd5,  mhz: 7'd48, xtal: 1'b1, hdiv: 4'd4,  rdiv: 2'd2, rsel: 1'b0, err: 1'b0},
        '{n: 5'd7,  mhz: 7'd36, xtal: 1'b0, hdiv: 4'd6,  rdiv: 2'd0, rsel: 1'b1, err: 1'b1},
        '{n: 5'd11, mhz: 7'd12, xtal: 1'b0, hdiv: 4'd8,  rdiv: 2'd0, rsel: 1'b1, err: 1'b0},
        '{n: 5'd20, mhz: 7'd48, xtal: 1'b1, hdiv: 4'd12, rdiv: 2'd2, rsel: 1'b0, err: 1'b0}
    };

    initial begin
        int snap_por, snap_busy;
        do_reset();
        @(negedge clk);
        // R11: everything low out of reset
        check({if_en, ref_sel, ref_div, rate_err, host_div, hdiv_en, hdiv_rst_n, phy_por,
               ate_rst, fs_rst_n, fs_en, phy_reset_n, host_reset_n, busy, done} == '0,
              "R11 outputs after reset", int'(phy_por | busy | done | if_en), 0);
        check(clients == 0, "R11 clients after reset", clients, 0);
        pulse(1'b0, 1'b1);
        check(clients == 0, "R1 stop at zero", clients, 0);

        foreach (VECS[k]) begin
            io_ratio = VECS[k].n; ref_mhz = VECS[k].mhz; ref_crystal = VECS[k].xtal;
            do_reset();
            pulse(1'b1, 1'b0);
            wait_done();
            check(done && host_reset_n, "R10 done after walk", int'(done), 1);
            check(host_div == VECS[k].hdiv, "R6 host_div", host_div, VECS[k].hdiv);
            check(ref_div == VECS[k].rdiv, "R4 ref_div", ref_div, VECS[k].rdiv);
            check(rate_err == VECS[k].err, "R4 rate_err", rate_err, VECS[k].err);
            check(ref_sel == VECS[k].rsel, "R5 ref_sel", ref_sel, VECS[k].rsel);
            check(t_hen < t_hrel, "R7 enable before release", t_hen, t_hrel - 1);
            check((t_porfall - t_hrel) >= 64 && (t_porfall - t_hrel) <= 67,
                  "R7 settle gap", t_porfall - t_hrel, 64);
            check((t_ate_on - t_porfall) >= MS_C && (t_ate_on - t_porfall) <= MS_C + 3,
                  "R8 ms gap", t_ate_on - t_porfall, MS_C);
            check((t_ate_off - t_ate_on) >= 1 && (t_ate_off - t_ate_on) <= 4,
                  "R8 ate pulse", t_ate_off - t_ate_on, 1);
            check((t_fsrel - t_ate_off) >= 1, "R8 post-ate gap", t_fsrel - t_ate_off, 1);
            check(t_fsen > t_fsrel, "R9 fs release before enable", t_fsen, t_fsrel + 1);
            check((t_phy - t_fsen) >= 64 && (t_phy - t_fsen) <= 67,
                  "R9 fs settle gap", t_phy - t_fsen, 64);
            check((t_host - t_phy) >= US_C && (t_host - t_phy) <= US_C + 3,
                  "R9 us gap", t_host - t_phy, US_C);
        end

        // R1: extra starts only count
        snap_por = por_rises;
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        check(clients == 3, "R1 count up", clients, 3);
        check(por_rises == snap_por && done, "R1 no rerun", por_rises - snap_por, 0);
        pulse(1'b1, 1'b1);
        check(clients == 3, "R1 start+stop holds", clients, 3);
        pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
        check(clients == 0, "R1 count down floor", clients, 0);
        check(done == 1, "R1 stop leaves done", done, 1);

        // R2: skip path with host already out of reset
        snap_por = por_rises; snap_busy = busy_cyc;
        pulse(1'b1, 1'b0);
        wait_done();
        check(por_rises == snap_por, "R2 no por on skip", por_rises - snap_por, 0);
        check(busy_cyc - snap_busy == 2, "R2 skip busy cycles", busy_cyc - snap_busy, 2);
        check(done && if_en && clients == 1, "R2 done after skip", int'(done), 1);

        // R10: start while busy is counted only
        do_reset();
        snap_por = por_rises;
        pulse(1'b1, 1'b0);
        repeat (100) @(negedge clk);
        check(busy && !done, "R10 busy mid walk", int'(busy), 1);
        pulse(1'b1, 1'b0);
        wait_done();
        check(clients == 2, "R10 count while busy", clients, 2);
        check(por_rises - snap_por == 1, "R10 no restart", por_rises - snap_por, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog: done actual=%0d expected=1", done);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule